// File: doc/BRIEF.md
# SD Command Line Controller

This block drives the command line of an SD or MMC card. A write to the command word with the enable bit set starts a command. The block then shifts out a 48-bit command frame, one bit per card clock strobe. The frame carries a start bit, a host direction bit, the 6-bit command index, the 32-bit argument, a CRC7 and an end bit. After the frame, the block can wait for a response, which is either a 48-bit short frame or a 136-bit long frame. It checks the response CRC when the selected mode asks for it and stores the response in four 32-bit words.

Each outcome is recorded in a sticky status flag. Software clears a flag by writing a one to the matching bit of the clear input. A mask register selects which status bits drive the interrupt. A command can also wait, after its response, for the card to release data line 0 from busy. All timing on the card side comes from a one-cycle strobe `ck_stb`, which marks each card clock period. The block drives and samples the line only on cycles where the strobe is high.

Command word layout:
- bits 5:0: command index
- bits 9:8: response mode
- bit 11: wait for busy release
- bit 12: enable

Bits 6, 7 and 10 mark data or stop commands for a neighbouring block and have no function here.

Top module: `sdcmd_path`

## Requirements
- R1: On the 48 strobes after a command starts, `cmd_out` carries, in this order: 0, 1, the index bits 5:0 MSB first, the argument MSB first, a CRC7 with polynomial x^7+x^3+1 over those first 40 bits (MSB first), and 1. `cmd_oe` is high only while that frame is driven, and `cmd_out` is 1 when the line is not driven.
- R2: Response mode 00 sets status bit 7 when the end bit has been driven, and waits for no response.
- R3: In mode 01, a short response with a correct CRC sets status bit 6 and leaves bit 0 clear. `resp0` then holds response bits 39:8 and `resp1` to `resp3` are zero.
- R4: In mode 01, a short response whose CRC7 (over its first 40 bits) does not match sets status bit 0 and leaves bit 6 clear.
- R5: In mode 10, a short response sets bit 6 whatever its CRC, and bit 0 stays clear.
- R6: In mode 11, a 136-bit response is received and its CRC7 over bits 127:8 is checked against bits 7:1. `resp0`, `resp1`, `resp2` and `resp3` then hold bits 127:96, 95:64, 63:32 and {31:1, 0}.
- R7: When a response is expected and no start bit (a 0) is sampled within 64 strobes after the frame's end bit, status bit 2 sets on the 64th strobe and not before.
- R8: Writing ones on `clr_bits` with `clr_wr` clears exactly those sticky flags (bits 0, 2, 6, 7, 21) and leaves the others.
- R9: `irq` is high when any status bit is set whose bit in the mask register (loaded by `mask_wr`) is 1.
- R10: With command word bit 11 set, after the response status bit 20 is high while data line 0 is low, and bit 21 sets when the line returns high.
- R11: A command-word write with bit 12 clear while a command is in progress returns the block to idle. It releases the line and sets no flag.
- R12: After reset, status, the response words and `irq` are zero, and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ck_stb | input | 1 | One-cycle strobe for each card clock period |
| cmd_wr | input | 1 | Command word write |
| cmd_word | input | 13 | Command word (index, mode, busy wait, enable) |
| cmd_arg | input | 32 | Command argument |
| cmd_in | input | 1 | Command line input from the card |
| dat0_in | input | 1 | Data line 0 input, low while the card is busy |
| clr_wr | input | 1 | Flag clear write |
| clr_bits | input | 32 | Ones clear the matching sticky flags |
| mask_wr | input | 1 | Mask register write |
| mask_bits | input | 32 | New mask value |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |
| status | output | 32 | Status flags |
| irq | output | 1 | Masked interrupt |

## Verification
The bench pushes the response timeout to its exact edge. A design that counts from the wrong strobe raises the timeout flag one sample early or late, or does not raise it at all. Short responses go through mode 01 and mode 10, both with a corrupted CRC. A block that ignores the mode reports a CRC fault in the no-check mode, or accepts bad data in the checked mode. A long response tests both the word order and the narrower CRC window; a shifted window or reversed words breaks the stored values. An abort in the middle of a frame, a partial flag clear and the busy release of data line 0 all check that no flag is set or lost that should not be.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int unsigned SHORT_W = 48;
  localparam int unsigned LONG_W  = 136;

  // status bit positions
  localparam int unsigned ST_CRC_FAIL = 0;
  localparam int unsigned ST_TIMEOUT  = 2;
  localparam int unsigned ST_RESP_OK  = 6;
  localparam int unsigned ST_SENT     = 7;
  localparam int unsigned ST_BUSY     = 20;
  localparam int unsigned ST_BUSY_END = 21;

  // command word bit positions
  localparam int unsigned CW_BUSYWAIT = 11;
  localparam int unsigned CW_EN       = 12;

  typedef enum logic [1:0] {
    RSP_NONE      = 2'b00,
    RSP_SHORT_CRC = 2'b01,
    RSP_SHORT_RAW = 2'b10,
    RSP_LONG      = 2'b11
  } rsp_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TX,
    S_WAIT,
    S_RX,
    S_BUSY
  } cmd_state_e;

  // one serial step of the x^7 + x^3 + 1 divider
  function automatic logic [6:0] crc7_step(input logic [6:0] crc, input logic din);
    logic fb;
    fb = din ^ crc[6];
    crc7_step = {crc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
  import sdcmd_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             load,
  input  logic             flush,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic             line,
  output logic             oe,
  output logic             done
);

  localparam int unsigned BODY_W  = ARG_W + IDX_W + 2;
  localparam int unsigned FRAME_W = BODY_W + 8;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] BODY_END = CNT_W'(BODY_W);
  localparam logic [CNT_W-1:0] CRC_END  = CNT_W'(BODY_W + 7);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_W - 1);

  logic [BODY_W-1:0] sr_q, sr_d;
  logic [6:0]        crc_q, crc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              act_q, act_d;
  logic              line_q, line_d, oe_q, oe_d;
  logic              bit_now;

  always_comb begin
    sr_d    = sr_q;
    crc_d   = crc_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    line_d  = line_q;
    oe_d    = oe_q;
    done    = 1'b0;
    bit_now = 1'b1;
    if (cnt_q < BODY_END)     bit_now = sr_q[BODY_W-1];
    else if (cnt_q < CRC_END) bit_now = crc_q[6];

    if (flush) begin
      act_d  = 1'b0;
      oe_d   = 1'b0;
      line_d = 1'b1;
    end else if (load) begin
      sr_d  = {2'b01, idx, arg};
      crc_d = '0;
      cnt_d = '0;
      act_d = 1'b1;
    end else if (stb) begin
      if (act_q) begin
        line_d = bit_now;
        oe_d   = 1'b1;
        if (cnt_q < BODY_END) begin
          sr_d  = {sr_q[BODY_W-2:0], 1'b0};
          crc_d = crc7_step(crc_q, bit_now);
        end else begin
          crc_d = {crc_q[5:0], 1'b0};
        end
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          act_d = 1'b0;
          done  = 1'b1;
        end
      end else begin
        line_d = 1'b1;
        oe_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      crc_q  <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      line_q <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      crc_q  <= crc_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      line_q <= line_d;
      oe_q   <= oe_d;
    end
  end

  assign line = line_q;
  assign oe   = oe_q;

endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
  import sdcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              listen,
  input  logic              flush,
  input  logic              long_mode,
  input  logic              line,
  output logic              done,
  output logic              crc_ok,
  output logic [LONG_W-1:0] frame
);

  localparam int unsigned CNT_W = $clog2(LONG_W + 1);
  // serial index 0 is the start bit
  localparam logic [CNT_W-1:0] S_LO   = CNT_W'(0);
  localparam logic [CNT_W-1:0] S_HI   = CNT_W'(SHORT_W - 2);
  localparam logic [CNT_W-1:0] S_LAST = CNT_W'(SHORT_W - 1);
  localparam logic [CNT_W-1:0] L_LO   = CNT_W'(8);
  localparam logic [CNT_W-1:0] L_HI   = CNT_W'(LONG_W - 2);
  localparam logic [CNT_W-1:0] L_LAST = CNT_W'(LONG_W - 1);

  logic [LONG_W-1:0] sr_q, sr_d;
  logic [6:0]        crc_q, crc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              act_q, act_d;
  logic [CNT_W-1:0]  lo, hi, last;

  always_comb begin
    lo    = long_mode ? L_LO   : S_LO;
    hi    = long_mode ? L_HI   : S_HI;
    last  = long_mode ? L_LAST : S_LAST;
    sr_d  = sr_q;
    crc_d = crc_q;
    cnt_d = cnt_q;
    act_d = act_q;
    done  = 1'b0;
    if (flush) begin
      act_d = 1'b0;
    end else if (stb) begin
      if (!act_q) begin
        if (listen && !line) begin
          act_d = 1'b1;
          cnt_d = CNT_W'(1);
          sr_d  = {sr_q[LONG_W-2:0], 1'b0};
          crc_d = '0;
        end
      end else begin
        sr_d = {sr_q[LONG_W-2:0], line};
        if (cnt_q >= lo && cnt_q <= hi) crc_d = crc7_step(crc_q, line);
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == last) begin
          act_d = 1'b0;
          done  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      crc_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      crc_q <= crc_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // residue of message plus its own CRC is zero when intact
  assign crc_ok = (crc_q == 7'd0);
  assign frame  = {sr_q[LONG_W-2:0], line};

endmodule

// File: rtl/sdcmd_path.sv
module sdcmd_path
  import sdcmd_pkg::*;
#(
  parameter int unsigned TMO_STROBES = 64,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned IDX_W       = 6,
  parameter int unsigned CMD_W       = 13,
  parameter int unsigned STAT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ck_stb,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [WORD_W-1:0] cmd_arg,
  input  logic              cmd_in,
  input  logic              dat0_in,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_bits,
  input  logic              mask_wr,
  input  logic [STAT_W-1:0] mask_bits,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic [WORD_W-1:0] resp0,
  output logic [WORD_W-1:0] resp1,
  output logic [WORD_W-1:0] resp2,
  output logic [WORD_W-1:0] resp3,
  output logic [STAT_W-1:0] status,
  output logic              irq
);

  localparam int unsigned TMO_W    = $clog2(TMO_STROBES);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_STROBES - 1);
  localparam int unsigned N_WORDS  = 4;

  // asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  cmd_state_e  state_q, state_d;
  rsp_mode_e   mode_q, mode_d;
  logic        bw_q, bw_d;
  logic        seen_q, seen_d;
  logic [TMO_W-1:0] tcnt_q, tcnt_d;
  logic [STAT_W-1:0] sticky_q, sticky_d, set_vec, lvl_vec;
  logic [STAT_W-1:0] mask_q;
  logic [N_WORDS-1:0][WORD_W-1:0] resp_q, resp_d, resp_long;
  logic        start, abort;
  logic        tx_done, rx_done, rx_crc_ok;
  logic [LONG_W-1:0] rx_frame;

  assign start = cmd_wr && cmd_word[CW_EN] && (state_q == S_IDLE);
  assign abort = cmd_wr && !cmd_word[CW_EN] && (state_q != S_IDLE);

  sdcmd_tx #(.IDX_W(IDX_W), .ARG_W(WORD_W)) tx_i (
    .clk(clk), .rst_n(rst_i_n), .stb(ck_stb), .load(start), .flush(abort),
    .idx(cmd_word[IDX_W-1:0]), .arg(cmd_arg),
    .line(cmd_out), .oe(cmd_oe), .done(tx_done)
  );

  sdcmd_rx rx_i (
    .clk(clk), .rst_n(rst_i_n), .stb(ck_stb), .listen(state_q == S_WAIT),
    .flush(abort), .long_mode(mode_q == RSP_LONG), .line(cmd_in),
    .done(rx_done), .crc_ok(rx_crc_ok), .frame(rx_frame)
  );

  for (genvar k = 0; k < N_WORDS; k++) begin : g_long
    if (k == N_WORDS - 1) begin : g_last
      assign resp_long[k] = {rx_frame[WORD_W-1:1], 1'b0};
    end else begin : g_mid
      assign resp_long[k] = rx_frame[(N_WORDS-k)*WORD_W-1 -: WORD_W];
    end
  end

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    bw_d    = bw_q;
    seen_d  = seen_q;
    tcnt_d  = tcnt_q;
    resp_d  = resp_q;
    set_vec = '0;
    case (state_q)
      S_IDLE: if (start) begin
        state_d = S_TX;
        mode_d  = rsp_mode_e'(cmd_word[9:8]);
        bw_d    = cmd_word[CW_BUSYWAIT];
      end
      S_TX: if (tx_done) begin
        if (mode_q == RSP_NONE) begin
          set_vec[ST_SENT] = 1'b1;
          state_d = S_IDLE;
        end else begin
          state_d = S_WAIT;
          tcnt_d  = '0;
        end
      end
      S_WAIT: if (ck_stb) begin
        if (!cmd_in) begin
          state_d = S_RX;
        end else if (tcnt_q == TMO_LAST) begin
          set_vec[ST_TIMEOUT] = 1'b1;
          state_d = S_IDLE;
        end else begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      S_RX: if (rx_done) begin
        if (mode_q == RSP_SHORT_RAW || rx_crc_ok) set_vec[ST_RESP_OK]  = 1'b1;
        else                                      set_vec[ST_CRC_FAIL] = 1'b1;
        if (mode_q == RSP_LONG) begin
          resp_d = resp_long;
        end else begin
          resp_d    = '0;
          resp_d[0] = rx_frame[WORD_W+7:8];
        end
        seen_d  = 1'b0;
        state_d = bw_q ? S_BUSY : S_IDLE;
      end
      S_BUSY: if (ck_stb) begin
        if (!dat0_in) begin
          seen_d = 1'b1;
        end else begin
          set_vec[ST_BUSY_END] = seen_q;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (abort) begin
      state_d = S_IDLE;
      set_vec = '0;
      resp_d  = resp_q;
    end
    sticky_d = (sticky_q & ~(clr_wr ? clr_bits : '0)) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q  <= S_IDLE;
      mode_q   <= RSP_NONE;
      bw_q     <= 1'b0;
      seen_q   <= 1'b0;
      tcnt_q   <= '0;
      sticky_q <= '0;
      mask_q   <= '0;
      resp_q   <= '0;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      bw_q     <= bw_d;
      seen_q   <= seen_d;
      tcnt_q   <= tcnt_d;
      sticky_q <= sticky_d;
      resp_q   <= resp_d;
      if (mask_wr) mask_q <= mask_bits;
    end
  end

  always_comb begin
    lvl_vec = '0;
    lvl_vec[ST_BUSY] = (state_q == S_BUSY) && !dat0_in;
  end

  assign status = sticky_q | lvl_vec;
  assign irq    = |(status & mask_q);
  assign resp0  = resp_q[0];
  assign resp1  = resp_q[1];
  assign resp2  = resp_q[2];
  assign resp3  = resp_q[3];

  logic unused_bits;
  assign unused_bits = ^{cmd_word[CMD_W-1:IDX_W], rx_frame[LONG_W-1:N_WORDS*WORD_W]};

endmodule

// File: rtl/sdcmd_path_chk.sv
module sdcmd_path_chk
  import sdcmd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input cmd_state_e  state,
  input logic        cmd_out,
  input logic        cmd_oe,
  input logic        cmd_wr,
  input logic [12:0] cmd_word,
  input logic [31:0] status,
  input logic        dat0_in,
  input logic        clr_wr,
  input logic [31:0] clr_bits
);

  // R1: released line idles high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_oe |-> cmd_out);

  // R4: one response never reports both CRC fault and success
  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(status[ST_CRC_FAIL]) && $rose(status[ST_RESP_OK])));

  // R7: timeout arises only from the response wait
  p_timeout_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_TIMEOUT]) |-> $past(state == S_WAIT));

  // R8: clearing in idle removes the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_bits[ST_RESP_OK] && state == S_IDLE) |=> !status[ST_RESP_OK]);

  // R10: busy level only while data line 0 is low
  p_busy_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_BUSY] |-> !dat0_in);

  // R11: abort releases the line and returns to idle
  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_word[CW_EN] && state != S_IDLE) |=> (state == S_IDLE && !cmd_oe));

endmodule

bind sdcmd_path sdcmd_path_chk chk_i (
  .clk(clk), .rst_n(rst_i_n), .state(state_q), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
  .cmd_wr(cmd_wr), .cmd_word(cmd_word), .status(status), .dat0_in(dat0_in),
  .clr_wr(clr_wr), .clr_bits(clr_bits)
);

// File: tb/sdcmd_path_tb_top.sv
`timescale 1ns/1ps
module sdcmd_path_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ck_stb = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [12:0] cmd_word = '0;
  logic [31:0] cmd_arg = '0;
  logic        cmd_in = 1'b1;
  logic        dat0_in = 1'b1;
  logic        clr_wr = 1'b0;
  logic [31:0] clr_bits = '0;
  logic        mask_wr = 1'b0;
  logic [31:0] mask_bits = '0;
  logic        cmd_out, cmd_oe, irq;
  logic [31:0] resp0, resp1, resp2, resp3, status;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  sdcmd_path dut_i (
    .clk(clk), .rst_n(rst_n), .ck_stb(ck_stb), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .cmd_arg(cmd_arg), .cmd_in(cmd_in), .dat0_in(dat0_in), .clr_wr(clr_wr),
    .clr_bits(clr_bits), .mask_wr(mask_wr), .mask_bits(mask_bits), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3),
    .status(status), .irq(irq)
  );

  always #4 clk = ~clk;

  // strobe generator, frame capture, card model
  int          div = 0;
  logic        cap [0:47];
  int          cap_n = 0;
  logic [135:0] card_frame = '0;
  int          card_len = 0, card_delay = 0, card_pos = 0;
  bit          card_act = 1'b0;

  always @(negedge clk) begin
    if (ck_stb && cmd_oe && cap_n < 48) begin
      cap[cap_n] = cmd_out;
      cap_n++;
    end
    div = (div == 3) ? 0 : div + 1;
    ck_stb = (div == 0);
    if (ck_stb && card_act) begin
      if (card_delay > 0) begin
        card_delay--;
        cmd_in = 1'b1;
      end else if (card_pos < card_len) begin
        cmd_in = card_frame[card_len-1-card_pos];
        card_pos++;
      end else begin
        cmd_in = 1'b1;
        card_act = 1'b0;
      end
    end
  end

  function automatic logic [6:0] crc_vec(input logic [135:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb;
      fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0} ^ (fb ? 7'b0001001 : 7'b0000000);
    end
    return c;
  endfunction

  function automatic logic [12:0] cw(input logic en, input logic bw,
                                     input logic [1:0] mode, input logic [5:0] idx);
    return {en, bw, 1'b0, mode, 2'b00, idx};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [12:0] w, input logic [31:0] a);
    @(negedge clk);
    cap_n = 0;
    cmd_word = w;
    cmd_arg = a;
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic clear(input logic [31:0] bits);
    @(negedge clk);
    clr_bits = bits;
    clr_wr = 1'b1;
    @(negedge clk);
    clr_wr = 1'b0;
  endtask

  task automatic set_mask(input logic [31:0] m);
    @(negedge clk);
    mask_bits = m;
    mask_wr = 1'b1;
    @(negedge clk);
    mask_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_stb(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!ck_stb) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic wait_frame();
    while (cap_n < 48) @(negedge clk);
  endtask

  task automatic wait_outcome();
    int k = 0;
    while (((status[6] | status[0] | status[2]) == 1'b0) && k < 3000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic card_send(input logic [135:0] f, input int len);
    card_frame = f;
    card_len = len;
    card_delay = 3;
    card_pos = 0;
    card_act = 1'b1;
  endtask

  function automatic logic [135:0] short_resp(input logic [5:0] idx, input logic [31:0] a,
                                              input bit bad);
    logic [39:0] m;
    logic [6:0]  c;
    m = {2'b00, idx, a};
    c = crc_vec({96'd0, m}, 40);
    if (bad) c[0] = ~c[0];
    return {88'd0, m, c, 1'b1};
  endfunction

  task automatic t_reset();
    chk("R12 status", status, 0);
    chk("R12 resp0", resp0, 0);
    chk("R12 irq/oe/line", {irq, cmd_oe, cmd_out}, 3'b001);
  endtask

  task automatic t_frame_nr();
    logic [47:0] exp, got;
    logic [39:0] m;
    clear('1);
    issue(cw(1, 0, 2'b00, 6'h11), 32'hA5C3_0F96);
    wait_frame();
    m = {2'b01, 6'h11, 32'hA5C3_0F96};
    exp = {m, crc_vec({96'd0, m}, 40), 1'b1};
    for (int i = 0; i < 48; i++) got[47-i] = cap[i];
    chk("R1 frame bits", got, exp);
    wait_stb(2);
    chk("R1 line released", {cmd_oe, cmd_out}, 2'b01);
    chk("R2 sent flag only", status, 32'h80);
  endtask

  task automatic t_short(input logic [1:0] mode, input bit bad, input logic [31:0] exp_stat,
                         input string req);
    clear('1);
    issue(cw(1, 0, mode, 6'h0D), 32'h0000_0900);
    wait_frame();
    card_send(short_resp(6'h0D, 32'h1234_5678, bad), 48);
    wait_outcome();
    wait_stb(2);
    chk(req, status, exp_stat);
    if (exp_stat == 32'h40) begin
      chk({req, " resp0"}, resp0, 32'h1234_5678);
      chk({req, " resp1-3 zero"}, {resp1, resp2[0], resp3[0]}, 0);
    end
  endtask

  task automatic t_long();
    logic [31:0] w0, w1, w2, w3;
    logic [119:0] pl;
    logic [6:0]   c;
    w0 = 32'hDEAD_BEEF; w1 = 32'h0123_4567; w2 = 32'h89AB_CDEF; w3 = 32'hCAFE_F00D;
    pl = {w0, w1, w2, w3[31:8]};
    c = crc_vec({16'd0, pl}, 120);
    clear('1);
    issue(cw(1, 0, 2'b11, 6'h02), 32'h0);
    wait_frame();
    card_send({2'b00, 6'b111111, pl, c, 1'b1}, 136);
    wait_outcome();
    wait_stb(2);
    chk("R6 long status", status, 32'h40);
    chk("R6 resp0/resp1", {resp0, resp1}, {w0, w1});
    chk("R6 resp2", resp2, w2);
    chk("R6 resp3", resp3, {w3[31:8], c, 1'b0});
  endtask

  task automatic t_timeout_clear_irq();
    clear('1);
    issue(cw(1, 0, 2'b01, 6'h08), 32'h1AA);
    wait_frame();
    wait_stb(63);
    chk("R7 no timeout at 63", status[2], 0);
    wait_stb(2);
    chk("R7 timeout at 64", status, 32'h4);
    issue(cw(1, 0, 2'b00, 6'h00), 32'h0);
    wait_frame();
    wait_stb(2);
    chk("R8 two flags", status, 32'h84);
    clear(32'h4);
    chk("R8 partial clear", status, 32'h80);
    set_mask(32'h0);
    chk("R9 masked off", irq, 0);
    set_mask(32'h80);
    chk("R9 enabled bit", irq, 1);
    set_mask(32'h40);
    chk("R9 other bit", irq, 0);
    clear(32'h80);
    chk("R8 all clear", status, 0);
    set_mask(32'h0);
  endtask

  task automatic t_busy();
    clear('1);
    dat0_in = 1'b0;
    issue(cw(1, 1, 2'b01, 6'h07), 32'h0);
    wait_frame();
    card_send(short_resp(6'h07, 32'h0000_0700, 0), 48);
    wait_outcome();
    wait_stb(5);
    chk("R10 busy level", status[21:20], 2'b01);
    dat0_in = 1'b1;
    wait_stb(2);
    chk("R10 busy end", status, 32'h0020_0040);
  endtask

  task automatic t_abort();
    clear('1);
    issue(cw(1, 0, 2'b01, 6'h11), 32'hFFFF_0000);
    while (cap_n < 10) @(negedge clk);
    issue(cw(0, 0, 2'b01, 6'h11), 32'h0);
    @(negedge clk);
    chk("R11 line released", cmd_oe, 0);
    wait_stb(100);
    chk("R11 no flag", status, 0);
    issue(cw(1, 0, 2'b00, 6'h00), 32'h0);
    wait_frame();
    wait_stb(2);
    chk("R11 next command runs", status, 32'h80);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_frame_nr();
    t_short(2'b01, 0, 32'h40, "R3 short ok");
    t_short(2'b01, 1, 32'h01, "R4 short crc fail");
    t_short(2'b10, 1, 32'h40, "R5 no-check mode");
    t_long();
    t_timeout_clear_irq();
    t_busy();
    t_abort();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule